// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between a SECDED check-bit generator and the storage array of a memory controller. Each stored codeword, 64 data bits plus 8 check bits, passes through it. A 16-bit control register tells it to flip one bit, or two adjacent bits, of that codeword before storage. A later read of the location then raises a correctable event or a non-correctable event. Diagnostic software uses the block to test the error-handling path without real faults in the memory.

The register has four mode flags and a 7-bit position field. The modes are continuous single-bit, one-shot single-bit, continuous double-bit and one-shot double-bit. A mode flag can be set only while the system-level injection enable input is high. At most one flag may be set at a time. Any other combination is held in the register but injects nothing. A continuous mode stops when the enable input drops, and it starts again only after the flag is written to 0 and then to 1. Each codeword strobe produces a registered output one cycle later.

Top module: `ecc_err_inject`

## Requirements
- R1: After reset the control register reads 0x0000 and `cw_out_vld` is low.
- R2: The register answers at address 0x4A. Bit 13 is continuous single-bit, bit 12 is one-shot single-bit, bit 9 is continuous double-bit and bit 8 is one-shot double-bit. Bits 6:0 hold the position. Bits 15, 14, 11, 10 and 7 read 0. A read returns data in `cfg_rdata` one cycle after `cfg_rd`. A read of any other address returns 0.
- R3: Each `cw_wr` strobe yields `cw_out_vld` high one cycle later. When no mode is active, `cw_out` equals the `cw_in` that was strobed.
- R4: With continuous single-bit active, every strobe inverts the codeword bit at the position field.
- R5: With one-shot single-bit active, only the next strobe inverts the selected bit. The flag then clears in hardware and reads 0.
- R6: The double-bit modes invert bit `pos` and bit `(pos+1) mod 72`. The continuous double-bit mode does this on every strobe. The one-shot double-bit mode does it once and then clears its flag.
- R7: A position value of 72 to 127 inverts no bit.
- R8: A write of 1 to a mode flag while `inj_enable` is low leaves the flag at 0. The position field is still written.
- R9: When `inj_enable` falls, an active continuous mode stops. Its flag still reads 1. Writing 1 again does not restart it. Writing 0 and then 1 restarts it.
- R10: If more than one mode flag is set, no bit is inverted and no one-shot flag is consumed.
- R11: A register write takes effect from the strobe in the following cycle. A strobe in the same cycle as the write uses the old setting.
- R12: A strobe while `inj_enable` is low passes unchanged. A pending one-shot mode stays pending and fires on the first strobe after the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register and codeword path |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write request |
| cfg_rd | input | 1 | Register read request |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data |
| inj_enable | input | 1 | System-level injection enable |
| cw_wr | input | 1 | Codeword write strobe |
| cw_in | input | 72 | Codeword from the check-bit generator |
| cw_out | output | 72 | Codeword toward storage, possibly corrupted |
| cw_out_vld | output | 1 | `cw_out` holds a fresh codeword |

## Verification
The assertions assume that `cw_in` is meaningful only in cycles with `cw_wr` high. They also assume that register and codeword accesses are synchronous to `clk` and that `rst` is held for at least one edge. The bench drives all inputs on the falling edge. It keeps `cw_wr` low outside its strobe task and drives no strobe or access during reset. The same-cycle case for R11 is the only time the bench issues a register write and a strobe together. Illegal mode combinations are written on purpose, but the bench strobes only once under them and then clears them.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int REG_W = 16;
  localparam int POS_W = 7;
  localparam int NMODE = 4;
  // register bit indices (software-visible layout)
  localparam int IDX_CONT_SB = 13;
  localparam int IDX_ONE_SB  = 12;
  localparam int IDX_CONT_DB = 9;
  localparam int IDX_ONE_DB  = 8;
  // internal mode vector ordering: [3]=cont_sb [2]=one_sb [1]=cont_db [0]=one_db
  localparam logic [NMODE-1:0] CONT_MASK = 4'b1010;
  localparam logic [NMODE-1:0] SB_MASK   = 4'b1100;
  localparam logic [REG_W-1:0] UNIMPL_MASK = 16'hCC80;

  function automatic logic [REG_W-1:0] pack_reg(input logic [NMODE-1:0] m,
                                                input logic [POS_W-1:0] p);
    logic [REG_W-1:0] r;
    r = '0;
    r[IDX_CONT_SB] = m[3];
    r[IDX_ONE_SB]  = m[2];
    r[IDX_CONT_DB] = m[1];
    r[IDX_ONE_DB]  = m[0];
    r[POS_W-1:0]   = p;
    return r;
  endfunction
endpackage

// File: rtl/ecc_inj_ctrl_reg.sv
module ecc_inj_ctrl_reg
  import ecc_inj_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h4A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NMODE-1:0]  wr_modes,
  input  logic [POS_W-1:0]  wr_pos,
  input  logic              inj_enable,
  input  logic [NMODE-1:0]  consume,
  output logic [NMODE-1:0]  modes,
  output logic [NMODE-1:0]  armed,
  output logic [POS_W-1:0]  pos,
  output logic [REG_W-1:0]  reg_val
);
  logic [NMODE-1:0] modes_d, armed_d;
  logic             wr_hit;

  assign wr_hit = cfg_wr && (cfg_addr == REG_OFS);

  always_comb begin
    modes_d = modes;
    armed_d = armed;
    for (int i = 0; i < NMODE; i++) begin
      if (CONT_MASK[i] && !inj_enable) armed_d[i] = 1'b0;
      if (!CONT_MASK[i] && consume[i]) begin
        modes_d[i] = 1'b0;
        armed_d[i] = 1'b0;
      end
      if (wr_hit) begin
        if (!wr_modes[i]) begin
          modes_d[i] = 1'b0;
          armed_d[i] = 1'b0;
        end else if (!modes[i] && inj_enable) begin
          modes_d[i] = 1'b1;
          armed_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modes <= '0;
      armed <= '0;
      pos   <= '0;
    end else begin
      modes <= modes_d;
      armed <= armed_d;
      if (wr_hit) pos <= wr_pos;
    end
  end

  assign reg_val = pack_reg(modes, pos);
endmodule

// File: rtl/ecc_inj_mask_gen.sv
module ecc_inj_mask_gen
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  logic [POS_W-1:0] pos,
  input  logic             en_single,
  input  logic             en_double,
  output logic [CW_W-1:0]  mask
);
  for (genvar b = 0; b < CW_W; b++) begin : g_bit
    localparam int PREV = (b == 0) ? CW_W - 1 : b - 1;
    assign mask[b] = ((en_single || en_double) && (pos == POS_W'(b))) ||
                     (en_double && (pos == POS_W'(PREV)));
  end
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h4A
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic                     cfg_rd,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [REG_W-1:0]         cfg_wdata,
  output logic [REG_W-1:0]         cfg_rdata,
  input  logic                     inj_enable,
  input  logic                     cw_wr,
  input  logic [DATA_W+CHK_W-1:0]  cw_in,
  output logic [DATA_W+CHK_W-1:0]  cw_out,
  output logic                     cw_out_vld
);
  localparam int CW_W = DATA_W + CHK_W;

  logic [NMODE-1:0] modes, armed, active, consume, wr_modes;
  logic [POS_W-1:0] pos;
  logic [REG_W-1:0] reg_val;
  logic [CW_W-1:0]  mask;
  logic             legal, en_single, en_double;
  logic             wdata_unused;

  assign wr_modes = {cfg_wdata[IDX_CONT_SB], cfg_wdata[IDX_ONE_SB],
                     cfg_wdata[IDX_CONT_DB], cfg_wdata[IDX_ONE_DB]};
  assign wdata_unused = ^(cfg_wdata & UNIMPL_MASK);

  ecc_inj_ctrl_reg #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) ctrl_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .wr_modes(wr_modes), .wr_pos(cfg_wdata[POS_W-1:0]),
    .inj_enable(inj_enable), .consume(consume),
    .modes(modes), .armed(armed), .pos(pos), .reg_val(reg_val)
  );

  assign legal     = ($countones(modes) <= 1);
  assign active    = modes & armed & {NMODE{legal && inj_enable}};
  assign en_single = |(active & SB_MASK);
  assign en_double = |(active & ~SB_MASK);
  assign consume   = active & ~CONT_MASK & {NMODE{cw_wr}};

  ecc_inj_mask_gen #(.CW_W(CW_W)) mask_i (
    .pos(pos), .en_single(en_single), .en_double(en_double), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_out     <= '0;
      cw_out_vld <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cw_out_vld <= cw_wr;
      if (cw_wr) cw_out <= cw_in ^ mask;
      cfg_rdata  <= (cfg_rd && cfg_addr == REG_OFS) ? reg_val : '0;
    end
  end
endmodule

// File: rtl/ecc_err_inject_chk.sv
module ecc_err_inject_chk
  import ecc_inj_pkg::*;
#(
  parameter int CW_W   = 72,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h4A
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              inj_enable,
  input logic              cw_wr,
  input logic [CW_W-1:0]   cw_in,
  input logic [CW_W-1:0]   cw_out,
  input logic              cw_out_vld
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cw_out_vld && cfg_rdata == '0));
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
    cw_wr |=> cw_out_vld);
  a_r3_vld_idle: assert property (@(posedge clk) disable iff (rst)
    !cw_wr |=> !cw_out_vld);
  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & UNIMPL_MASK) == '0);
  a_r2_other_addr: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr != REG_OFS) |=> cfg_rdata == '0);
  a_r6_max_two_flips: assert property (@(posedge clk) disable iff (rst)
    cw_out_vld |-> $countones(cw_out ^ $past(cw_in)) <= 2);
  a_r12_gate_low: assert property (@(posedge clk) disable iff (rst)
    (cw_wr && !inj_enable) |=> cw_out == $past(cw_in));
endmodule

bind ecc_err_inject ecc_err_inject_chk #(
  .CW_W(DATA_W + CHK_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)
) chk_i (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .inj_enable(inj_enable), .cw_wr(cw_wr),
  .cw_in(cw_in), .cw_out(cw_out), .cw_out_vld(cw_out_vld)
);

// File: tb/ecc_err_inject_tb_top.sv
module ecc_err_inject_tb_top;
  localparam int CW = 72;
  localparam logic [7:0] OFS = 8'h4A;
  localparam logic [15:0] M_CS = 16'h2000, M_OS = 16'h1000,
                          M_CD = 16'h0200, M_OD = 16'h0100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_wr = 0, cfg_rd = 0, inj_enable = 1, cw_wr = 0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [CW-1:0] cw_in = '0;
  logic [15:0] cfg_rdata;
  logic [CW-1:0] cw_out;
  logic cw_out_vld;

  int errs = 0, checks = 0;
  logic [CW-1:0] exp_q[$];
  string tag_q[$];

  ecc_err_inject dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .inj_enable(inj_enable), .cw_wr(cw_wr), .cw_in(cw_in),
    .cw_out(cw_out), .cw_out_vld(cw_out_vld)
  );

  function automatic logic [CW-1:0] flip(input logic [CW-1:0] d, input int p, input bit dbl);
    logic [CW-1:0] r = d;
    if (p < CW) begin
      r[p] = ~r[p];
      if (dbl) r[(p + 1) % CW] = ~r[(p + 1) % CW];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] rnd();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cw_out_vld) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected output", cw_out, '0);
      else begin
        logic [CW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cw_out === e, t, cw_out, e);
      end
    end
  end

  task automatic strobe(input logic [CW-1:0] d, input logic [CW-1:0] e, input string tag);
    @(negedge clk);
    cw_wr = 1; cw_in = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    cw_wr = 0;
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = OFS; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    check(cfg_rdata === e, tag, CW'(cfg_rdata), CW'(e));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog timeout", '0, '1);
    summary();
    $finish;
  end

  initial begin
    logic [CW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cw_out_vld === 1'b0, "R1 vld after reset", CW'(cw_out_vld), '0);
    reg_read(OFS, 16'h0000, "R1 register reset value");

    // R3 pass-through
    for (int i = 0; i < 3; i++) begin d = rnd(); strobe(d, d, "R3 pass-through"); end

    // R2 layout, address decode, unimplemented bits
    reg_write(16'h0005);
    reg_read(8'h40, 16'h0000, "R2 other address reads 0");
    reg_read(OFS, 16'h0005, "R2 position readback");
    inj_enable = 0;
    reg_write(16'hFFFF);
    reg_read(OFS, 16'h007F, "R8 R2 gated modes, unimpl zero");
    inj_enable = 1;
    reg_write(16'h0000);

    // R4 continuous single
    reg_write(M_CS | 16'd10);
    reg_read(OFS, M_CS | 16'd10, "R2 continuous single flag bit13");
    for (int i = 0; i < 2; i++) begin d = rnd(); strobe(d, flip(d, 10, 0), "R4 continuous single"); end
    reg_write(16'h0000);

    // R5 one-shot single
    reg_write(M_OS | 16'd3);
    d = rnd(); strobe(d, flip(d, 3, 0), "R5 one-shot fires");
    d = rnd(); strobe(d, d, "R5 one-shot only once");
    reg_read(OFS, 16'h0003, "R5 one-shot self-clears");

    // R6 double modes
    reg_write(M_CD | 16'd71);
    for (int i = 0; i < 2; i++) begin d = rnd(); strobe(d, flip(d, 71, 1), "R6 continuous double wrap"); end
    reg_write(16'h0000);
    reg_write(M_OD | 16'd20);
    d = rnd(); strobe(d, flip(d, 20, 1), "R6 one-shot double");
    d = rnd(); strobe(d, d, "R6 one-shot double once");
    reg_read(OFS, 16'd20, "R6 one-shot double clears");

    // R7 out-of-range position
    reg_write(M_CS | 16'd100);
    d = rnd(); strobe(d, d, "R7 position 100 no flip");
    reg_write(16'h0000);

    // R8 gated set
    inj_enable = 0;
    reg_write(M_CS | 16'd5);
    inj_enable = 1;
    reg_read(OFS, 16'h0005, "R8 set while disabled stays 0");
    d = rnd(); strobe(d, d, "R8 no injection");

    // R9 re-arm sequence
    reg_write(M_CS | 16'd7);
    d = rnd(); strobe(d, flip(d, 7, 0), "R9 armed");
    @(negedge clk); inj_enable = 0;
    @(negedge clk); inj_enable = 1;
    reg_read(OFS, M_CS | 16'd7, "R9 flag still reads 1");
    d = rnd(); strobe(d, d, "R9 stopped after enable drop");
    reg_write(M_CS | 16'd7);
    d = rnd(); strobe(d, d, "R9 set-while-set no rearm");
    reg_write(16'd7);
    reg_write(M_CS | 16'd7);
    d = rnd(); strobe(d, flip(d, 7, 0), "R9 clear-then-set rearms");
    reg_write(16'h0000);

    // R10 illegal combination
    reg_write(M_CS | M_OS | 16'd4);
    d = rnd(); strobe(d, d, "R10 illegal combo no flip");
    reg_read(OFS, 16'h3004, "R10 one-shot not consumed");
    reg_write(16'h0000);

    // R12 strobe while disabled, one-shot pending
    reg_write(M_OS | 16'd2);
    @(negedge clk); inj_enable = 0;
    d = rnd(); strobe(d, d, "R12 disabled strobe passes");
    inj_enable = 1;
    d = rnd(); strobe(d, flip(d, 2, 0), "R12 pending one-shot fires");

    // R11 same-cycle write uses old setting
    d = rnd();
    @(negedge clk);
    cfg_wr = 1; cfg_addr = OFS; cfg_wdata = M_CS | 16'd8;
    cw_wr = 1; cw_in = d;
    exp_q.push_back(d); tag_q.push_back("R11 same-cycle uses old");
    @(negedge clk);
    cfg_wr = 0; cw_wr = 0;
    d = rnd(); strobe(d, flip(d, 8, 0), "R11 next strobe uses new");
    reg_write(16'h0000);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all outputs seen", CW'(exp_q.size()), '0);
    summary();
    $finish;
  end
endmodule